// File: doc/BRIEF.md
# Output Port Buffer Steering with Borrowed Overflow Storage

This block is the buffering front end of one non-local output port in a network-on-chip router. Several input ports ask for the output, and a round-robin arbiter admits at most one 8-bit flit per cycle. Each admitted flit goes into a private static FIFO. When that FIFO is full and a shared floating FIFO has been lent to this port, the flit goes into the floating FIFO instead. The floating FIFO sits outside the block and is reached through write and read handshakes. Its data is read as first-word-fall-through.

Both FIFOs drain toward the downstream link over a ready/valid interface. When both hold flits for this port, they take turns. The block counts how many of its own flits sit in the floating FIFO, so it keeps draining them after the lending controller withdraws the assignment. It also reports two registered flags to that controller: static-full and own-floating-empty.

Top module: `opbuf_steer`

## Requirements
- R1: During and right after reset, no grant is issued, `out_valid_o` is low, `stat_full_o` is low and `flt_empty_o` is high.
- R2: At most one grant bit is high in any cycle. Requests are searched round-robin, starting at the input after the last one granted (input 0 first after reset). Grants are combinational in the cycle of the request.
- R3: A granted flit (taken from bits `[8*i+7:8*i]` of `flit_i` for grant bit i) is written to the static FIFO when that FIFO holds fewer than `DEPTH` flits. Flits leave it in arrival order.
- R4: When the static FIFO is full, `flt_assigned_i` is high and `flt_full_i` is low, the granted flit is written to the floating FIFO. In that cycle `flt_wr_o` is high and `flt_wdata_o` carries the flit.
- R5: No grant is issued while the static FIFO is full and the floating FIFO is either full or not assigned.
- R6: Exactly one of the two FIFOs takes a granted flit. `flt_wr_o` is never high while the static FIFO has room.
- R7: `out_valid_o` is high whenever the static FIFO or this port's share of the floating FIFO holds a flit. A flit is removed only in a cycle with `out_ready_i` high.
- R8: When both FIFOs hold flits, the output alternates between them, switching after each accepted transfer. After reset the static FIFO goes first. When only one FIFO holds flits, that FIFO is served.
- R9: With `flt_assigned_i` low, no flit is written to the floating FIFO, but flits already there are still delivered at the output.
- R10: `stat_full_o` is registered and is high exactly when the static FIFO holds `DEPTH` flits. `flt_empty_o` is registered and is high exactly when none of this port's flits remain in the floating FIFO.
- R11: `flt_rd_o` is high only in a cycle where a flit taken from the floating FIFO is accepted downstream. The flit presented is then `flt_rdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_IN | Per-input request |
| gnt_o | output | N_IN | One-hot grant |
| flit_i | input | 8*N_IN | Flits of all inputs, input i at bits 8*i+7:8*i |
| flt_assigned_i | input | 1 | Floating FIFO lent to this port |
| flt_full_i | input | 1 | Floating FIFO full |
| flt_wr_o | output | 1 | Floating FIFO write strobe |
| flt_wdata_o | output | 8 | Floating FIFO write data |
| flt_rd_o | output | 1 | Floating FIFO pop strobe |
| flt_rdata_i | input | 8 | Floating FIFO head (fall-through) |
| out_valid_o | output | 1 | Downstream flit valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | 8 | Downstream flit |
| stat_full_o | output | 1 | Registered static-full flag |
| flt_empty_o | output | 1 | Registered own-floating-empty flag |

## Verification
The bench builds the block with four inputs, a static depth of 16 and a floating counter sized for a depth of 4. The bench models the floating FIFO with that capacity of 4. These small values let directed phases fill both FIFOs quickly, which reaches the no-grant state and the alternating drain. Round-robin wrap-around across four inputs occurs often under random requests. Random toggling of the assignment and of downstream ready then exercises draining after withdrawal, and writes that return to the static FIFO once it frees a slot.

// File: rtl/opbuf_pkg.sv
package opbuf_pkg;
    localparam int FLIT_W = 8;
    typedef logic [FLIT_W-1:0] flit_t;
    // which storage feeds the output link this cycle
    typedef enum logic {SRC_STATIC = 1'b0, SRC_FLOAT = 1'b1} src_e;

    function automatic int wrap_idx(input int base, input int step, input int n);
        return (base + step) % n;
    endfunction
endpackage

// File: rtl/opbuf_rr_arb.sv
module opbuf_rr_arb #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          en,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx
);
    import opbuf_pkg::*;

    logic [IW-1:0] last_q;
    logic          found;

    always_comb begin
        int k;
        gnt   = '0;
        idx   = '0;
        found = 1'b0;
        for (int i = 1; i <= N; i++) begin
            k = wrap_idx(int'(last_q), i, N);
            if (!found && req[k]) begin
                found  = 1'b1;
                gnt[k] = 1'b1;
                idx    = IW'(k);
            end
        end
        if (!en) begin
            gnt   = '0;
            found = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        last_q <= IW'(N - 1);
        else if (found) last_q <= idx;
    end
endmodule

// File: rtl/opbuf_sfifo.sv
module opbuf_sfifo #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  opbuf_pkg::flit_t  din,
    input  logic              rd,
    output opbuf_pkg::flit_t  dout,
    output logic [CW-1:0]     count,
    output logic              full,
    output logic              empty
);
    import opbuf_pkg::*;

    flit_t         mem [DEPTH];
    logic [AW-1:0] wp, rp;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (wr) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr) wp <= wp + 1'b1;
            if (rd) rp <= rp + 1'b1;
            count <= count + CW'(wr) - CW'(rd);
        end
    end
endmodule

// File: rtl/opbuf_drain.sv
module opbuf_drain (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_has,
    input  logic              fl_has,
    input  logic              ready,
    input  opbuf_pkg::flit_t  st_data,
    input  opbuf_pkg::flit_t  fl_data,
    output logic              valid,
    output opbuf_pkg::flit_t  data,
    output logic              st_rd,
    output logic              fl_rd
);
    import opbuf_pkg::*;

    src_e turn_q;   // preferred source when both hold flits
    src_e src;
    logic xfer;

    assign valid = st_has | fl_has;
    assign src   = (fl_has && (!st_has || turn_q == SRC_FLOAT)) ? SRC_FLOAT : SRC_STATIC;
    assign data  = (src == SRC_FLOAT) ? fl_data : st_data;
    assign xfer  = valid & ready;
    assign st_rd = xfer & (src == SRC_STATIC);
    assign fl_rd = xfer & (src == SRC_FLOAT);

    always_ff @(posedge clk) begin
        if (rst)       turn_q <= SRC_STATIC;
        else if (xfer) turn_q <= (src == SRC_FLOAT) ? SRC_STATIC : SRC_FLOAT;
    end
endmodule

// File: rtl/opbuf_steer.sv
module opbuf_steer
    import opbuf_pkg::*;
#(
    parameter int N_IN      = 4,
    parameter int DEPTH     = 16,
    parameter int FLT_DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_IN-1:0]        req_i,
    output logic [N_IN-1:0]        gnt_o,
    input  logic [N_IN*FLIT_W-1:0] flit_i,
    input  logic                   flt_assigned_i,
    input  logic                   flt_full_i,
    output logic                   flt_wr_o,
    output logic [FLIT_W-1:0]      flt_wdata_o,
    output logic                   flt_rd_o,
    input  logic [FLIT_W-1:0]      flt_rdata_i,
    output logic                   out_valid_o,
    input  logic                   out_ready_i,
    output logic [FLIT_W-1:0]      out_data_o,
    output logic                   stat_full_o,
    output logic                   flt_empty_o
);
    localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam int SCW = $clog2(DEPTH + 1);
    localparam int FCW = $clog2(FLT_DEPTH + 1);

    logic           st_full, st_empty, st_wr, st_rd, room, any_gnt;
    logic [SCW-1:0] st_cnt, st_cnt_nxt;
    logic [FCW-1:0] own_cnt, own_nxt;
    logic [IW-1:0]  gidx;
    flit_t          flit_sel, st_dout;

    // admission is possible when either storage can take a flit
    assign room = ~st_full | (flt_assigned_i & ~flt_full_i);

    opbuf_rr_arb #(.N(N_IN)) u_arb (
        .clk (clk), .rst (rst), .req (req_i), .en (room),
        .gnt (gnt_o), .idx (gidx)
    );

    assign any_gnt     = |gnt_o;
    assign flit_sel    = flit_i[int'(gidx)*FLIT_W +: FLIT_W];
    assign st_wr       = any_gnt & ~st_full;
    assign flt_wr_o    = any_gnt & st_full;
    assign flt_wdata_o = flit_sel;

    opbuf_sfifo #(.DEPTH(DEPTH)) u_sfifo (
        .clk (clk), .rst (rst), .wr (st_wr), .din (flit_sel),
        .rd (st_rd), .dout (st_dout), .count (st_cnt),
        .full (st_full), .empty (st_empty)
    );

    opbuf_drain u_drain (
        .clk (clk), .rst (rst),
        .st_has (~st_empty), .fl_has (own_cnt != '0), .ready (out_ready_i),
        .st_data (st_dout), .fl_data (flt_rdata_i),
        .valid (out_valid_o), .data (out_data_o),
        .st_rd (st_rd), .fl_rd (flt_rd_o)
    );

    assign st_cnt_nxt = st_cnt + SCW'(st_wr) - SCW'(st_rd);
    assign own_nxt    = own_cnt + FCW'(flt_wr_o) - FCW'(flt_rd_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            own_cnt     <= '0;
            stat_full_o <= 1'b0;
            flt_empty_o <= 1'b1;
        end else begin
            own_cnt     <= own_nxt;
            stat_full_o <= (st_cnt_nxt == SCW'(DEPTH));
            flt_empty_o <= (own_nxt == '0);
        end
    end
endmodule

// File: rtl/opbuf_steer_chk.sv
module opbuf_steer_chk #(
    parameter int N_IN = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [N_IN-1:0] gnt_o,
    input logic            flt_assigned_i,
    input logic            flt_full_i,
    input logic            flt_wr_o,
    input logic            flt_rd_o,
    input logic            out_valid_o,
    input logic            out_ready_i,
    input logic            stat_full_o,
    input logic            flt_empty_o
);
    assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o));

    // R4 / R6: floating write only when static is full and the loan is usable
    assert_flt_wr_legal_R4: assert property (@(posedge clk) disable iff (rst)
        flt_wr_o |-> (stat_full_o && flt_assigned_i && !flt_full_i && gnt_o != '0));

    assert_no_grant_full_R5: assert property (@(posedge clk) disable iff (rst)
        (stat_full_o && (flt_full_i || !flt_assigned_i)) |-> (gnt_o == '0));

    assert_valid_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_ready_i) |=> out_valid_o);

    assert_flt_rd_legal_R11: assert property (@(posedge clk) disable iff (rst)
        flt_rd_o |-> (out_valid_o && out_ready_i && !flt_empty_o));

    assert_withdrawn_no_write_R9: assert property (@(posedge clk) disable iff (rst)
        !flt_assigned_i |-> !flt_wr_o);
endmodule

bind opbuf_steer opbuf_steer_chk #(.N_IN(N_IN)) u_chk (.*);

// File: tb/opbuf_steer_tb.sv
module opbuf_steer_tb;
    localparam int N  = 4;
    localparam int D  = 16;
    localparam int FD = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   req_i = '0;
    logic [N-1:0]   gnt_o;
    logic [N*8-1:0] flit_i = '0;
    logic           flt_assigned_i = 1'b0;
    logic           flt_full_i = 1'b0;
    logic           flt_wr_o, flt_rd_o;
    logic [7:0]     flt_wdata_o;
    logic [7:0]     flt_rdata_i = '0;
    logic           out_valid_o;
    logic           out_ready_i = 1'b0;
    logic [7:0]     out_data_o;
    logic           stat_full_o, flt_empty_o;

    always #2 clk = ~clk;

    opbuf_steer #(.N_IN(N), .DEPTH(D), .FLT_DEPTH(FD)) u_dut (.*);

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] sq[$];
    logic [7:0] fq[$];
    int  last = N - 1;
    bit  turn = 1'b0;
    bit  p_pop_s, p_pop_f, p_push_s, p_push_f;
    logic [7:0] p_dat;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: %s got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int pick(input logic [N-1:0] r, input bit room);
        int w = -1;
        if (room)
            for (int i = 1; i <= N; i++)
                if (w < 0 && r[(last + i) % N]) w = (last + i) % N;
        return w;
    endfunction

    task automatic step(input logic [N-1:0] r, input bit asg, input bit rdy);
        int w;
        bit room, sh, fh, ev, sel;
        string tg;
        @(negedge clk);
        if (p_pop_s)  void'(sq.pop_front());
        if (p_pop_f)  void'(fq.pop_front());
        if (p_push_s) sq.push_back(p_dat);
        if (p_push_f) fq.push_back(p_dat);
        flt_full_i  = (fq.size() >= FD);
        flt_rdata_i = (fq.size() > 0) ? fq[0] : 8'h00;
        req_i = r;
        flt_assigned_i = asg;
        out_ready_i = rdy;
        for (int i = 0; i < N; i++) flit_i[i*8 +: 8] = 8'($urandom);
        #1;
        room = (sq.size() < D) || (asg && fq.size() < FD);
        w = pick(r, room);
        chk((!room && r != '0) ? "R5" : "R2", "gnt", int'(gnt_o), (w >= 0) ? (1 << w) : 0);
        tg = (w >= 0 && sq.size() < D) ? "R6" : (!asg ? "R9" : "R4");
        chk(tg, "flt_wr", int'(flt_wr_o), int'(w >= 0 && sq.size() == D));
        if (w >= 0 && sq.size() == D)
            chk("R4", "flt_wdata", int'(flt_wdata_o), int'(flit_i[w*8 +: 8]));
        sh = sq.size() > 0;
        fh = fq.size() > 0;
        ev = sh | fh;
        sel = fh && (!sh || turn);
        chk("R7", "out_valid", int'(out_valid_o), int'(ev));
        if (ev) begin
            tg = (fh && !asg) ? "R9" : ((sh && fh) ? "R8" : "R3");
            chk(tg, "out_data", int'(out_data_o), int'(sel ? fq[0] : sq[0]));
        end
        chk("R11", "flt_rd", int'(flt_rd_o), int'(ev && rdy && sel));
        chk("R10", "stat_full", int'(stat_full_o), int'(sq.size() == D));
        chk("R10", "flt_empty", int'(flt_empty_o), int'(fq.size() == 0));
        p_pop_s  = ev && rdy && !sel;
        p_pop_f  = ev && rdy && sel;
        p_push_s = (w >= 0) && sq.size() < D;
        p_push_f = (w >= 0) && sq.size() == D;
        p_dat    = (w >= 0) ? flit_i[w*8 +: 8] : 8'h00;
        if (ev && rdy) turn = !sel;
        if (w >= 0) last = w;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit asg;
        void'($urandom(32'd1234));
        p_pop_s = 0; p_pop_f = 0; p_push_s = 0; p_push_f = 0; p_dat = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "gnt", int'(gnt_o), 0);
        chk("R1", "out_valid", int'(out_valid_o), 0);
        chk("R1", "stat_full", int'(stat_full_o), 0);
        chk("R1", "flt_empty", int'(flt_empty_o), 1);
        rst = 1'b0;
        // fill static without a loan, then reach the no-grant state (R3, R5)
        for (int i = 0; i < 20; i++) step(4'b1111, 1'b0, 1'b0);
        // lend the floating FIFO: overflow writes until it fills (R4, R5)
        for (int i = 0; i < 7; i++) step(4'($urandom) | 4'b0001, 1'b1, 1'b0);
        // withdraw and drain: alternation and floating drain (R8, R9, R11)
        for (int i = 0; i < 24; i++) step('0, 1'b0, 1'b1);
        // random traffic
        asg = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 39) == 0) asg = ~asg;
            step(4'($urandom), asg, ($urandom_range(0, 2) != 0) ? 1'b0 : 1'b1);
        end
        for (int i = 0; i < 40; i++) step('0, 1'b0, 1'b1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule